// File: doc/BRIEF.md
# Pixel Matrix Configuration and Hit-Readout Chain

This block is the digital spine of a pixel sensor matrix. One serial path threads every pixel cell of a `COLS` x `ROWS` array. In hit mode, each cell remembers whether its discriminator fired. The stored flags can then be clocked out bit by bit at the matrix edge, so the sensor can be read with nothing bonded to it. In configuration mode, the same thread of cells becomes a wider path that carries a 7-bit word per pixel. A strobe copies that word into the pixel's configuration latches, which drive the front end.

A global shift-enable chooses between two states. When it is low the cells record and hold. When it is high the path moves one position toward the serial output on every clock. A readback mode copies the live latch contents back into the path, so a written configuration can be verified from outside. The analog front end, the trim DAC and the bias generation sit outside this block. All sequential logic runs on one clock, which is also the shift clock, and uses a synchronous active-high reset.

Top module: `pixmatrix_chain`

## Requirements
- R1: A synchronous reset clears every hit flag and every configuration latch. After reset, all trim, preamplifier-enable, injection-enable and monitor-enable outputs are 0, and both a hit readout and a configuration readback return all zeros.
- R2: With `modeSel`=0 and `shiftEn`=0, a rising edge on `discIn[p]` sets the hit flag of pixel p. The flag stays set through further pulses and through idle cycles until it is cleared or shifted out.
- R3: While `shiftEn`=1, discriminator activity is ignored. A discriminator input that rises during shifting and is still high after shifting stops creates no hit.
- R4: Pixel index is p = row*COLS + col, and pixel 0 is nearest the output. In hit mode with `shiftEn`=1, each clock moves every hit flag one pixel toward `serOut`, and `serIn` enters at pixel NPIX-1. `serOut` shows pixel 0 before the first shift and pixel k after k shifts.
- R5: With `modeSel`=0, a `loadStb` pulse clears all hit flags.
- R6: In modes 1 and 2 with `shiftEn`=1, the configuration path is 7 bits per pixel, with flat position j = 7p + b. The first bit shifted in, and the first bit shifted out, is bit 0 of pixel 0.
- R7: With `modeSel`=1, `loadStb` copies the configuration path into all latches at once. Word bits [3:0] are the unsigned trim value, bit 4 is preamplifier enable, bit 5 is injection enable and bit 6 is monitor enable. Shifting alone changes no latch output.
- R8: The configuration latches keep their values through hit capture, hit readout, hit clearing, readback copies and configuration shifting.
- R9: With `modeSel`=2, `loadStb` copies every latch into the configuration path, which then reads out in the order given in R6.
- R10: In modes 1 and 2, the path holds while `shiftEn`=0. When `loadStb` and `shiftEn` are both high, only the strobe action is taken and nothing shifts.
- R11: `modeSel`=3 is idle: no hit is captured, cleared or shifted, and no latch or path bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and capture clock |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial data entering at the far end of the path |
| shiftEn | input | 1 | Global enable: 0 records or holds, 1 shifts |
| loadStb | input | 1 | Strobe: clear hits (mode 0), load latches (mode 1), copy latches back (mode 2) |
| modeSel | input | 2 | 0 hit, 1 configuration write, 2 configuration readback, 3 idle |
| discIn | input | COLS*ROWS | Per-pixel discriminator outputs, bit p for pixel p |
| serOut | output | 1 | Serial data at the pixel-0 end of the path |
| cfgTrim | output | 4*COLS*ROWS | Per-pixel trim code, bits [4p+3:4p] |
| cfgPreampEn | output | COLS*ROWS | Per-pixel preamplifier enable |
| cfgInjEn | output | COLS*ROWS | Per-pixel injection enable |
| cfgMonEn | output | COLS*ROWS | Per-pixel monitor enable |

## Verification
The bench builds the block with `COLS`=3 and `ROWS`=4. This gives 12 pixels and an 84-bit configuration path, so each full write, full readback and full hit readout can check every pixel and every bit position. Because the grid is not square, a swap of row and column order would put hits at the wrong serial positions. The defaults of 24 by 114 only lengthen the path, and change none of its ordering or strobe priorities.

// File: rtl/pixchain_pkg.sv
package pixchain_pkg;

  localparam int CFG_BITS  = 7;
  localparam int TRIM_BITS = 4;

  localparam logic [1:0] MODE_HIT      = 2'd0;
  localparam logic [1:0] MODE_CFG_WR   = 2'd1;
  localparam logic [1:0] MODE_CFG_RD   = 2'd2;
  localparam logic [1:0] MODE_IDLE     = 2'd3;

  // Word layout as seen on the serial path: bit 0 travels first.
  typedef struct packed {
    logic                 monEn;     // bit 6
    logic                 injEn;     // bit 5
    logic                 preampEn;  // bit 4
    logic [TRIM_BITS-1:0] trim;      // bits 3..0
  } pixCfg_t;

  // Control-to-datapath strobes; the action fields are mutually exclusive.
  typedef struct packed {
    logic capture;
    logic hitShift;
    logic hitClear;
    logic cfgShift;
    logic cfgLoad;
    logic cfgCopyBack;
    logic outFromCfg;
  } chainStrobe_t;

endpackage

// File: rtl/pixchain_ctrl.sv
module pixchain_ctrl
  import pixchain_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         shiftEn,
  input  logic         loadStb,
  input  logic [1:0]   modeSel,
  output chainStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    case (modeSel)
      MODE_HIT: begin
        if (loadStb)      strobe.hitClear = 1'b1;
        else if (shiftEn) strobe.hitShift = 1'b1;
        else              strobe.capture  = 1'b1;
      end
      MODE_CFG_WR: begin
        strobe.outFromCfg = 1'b1;
        if (loadStb)      strobe.cfgLoad  = 1'b1;
        else if (shiftEn) strobe.cfgShift = 1'b1;
      end
      MODE_CFG_RD: begin
        strobe.outFromCfg = 1'b1;
        if (loadStb)      strobe.cfgCopyBack = 1'b1;
        else if (shiftEn) strobe.cfgShift    = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

  // A strobe always wins over shifting; at most one action per clock.
  assert_single_action_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.capture, strobe.hitShift, strobe.hitClear,
              strobe.cfgShift, strobe.cfgLoad, strobe.cfgCopyBack}));

  assert_idle_mode_R11: assert property (@(posedge clk) disable iff (rst)
    (modeSel == MODE_IDLE) |-> (strobe == '0));

endmodule

// File: rtl/pixchain_cell.sv
module pixchain_cell
  import pixchain_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  chainStrobe_t        strobe,
  input  logic                discIn,
  input  logic                hitFromNext,
  input  logic                cfgFromNext,
  output logic                hitQ,
  output logic [CFG_BITS-1:0] cfgSrQ,
  output pixCfg_t             cfgLatQ
);

  logic discPrev;
  logic discRise;

  always_ff @(posedge clk) begin
    if (rst) discPrev <= 1'b0;
    else     discPrev <= discIn;
  end

  assign discRise = discIn & ~discPrev;

  // Hit flag: clear beats shift beats capture.
  always_ff @(posedge clk) begin
    if (rst)                              hitQ <= 1'b0;
    else if (strobe.hitClear)             hitQ <= 1'b0;
    else if (strobe.hitShift)             hitQ <= hitFromNext;
    else if (strobe.capture && discRise)  hitQ <= 1'b1;
  end

  // Configuration shift stage, LSB nearest the output.
  always_ff @(posedge clk) begin
    if (rst)                     cfgSrQ <= '0;
    else if (strobe.cfgCopyBack) cfgSrQ <= cfgLatQ;
    else if (strobe.cfgShift)    cfgSrQ <= {cfgFromNext, cfgSrQ[CFG_BITS-1:1]};
  end

  // Configuration latches, written only by the load strobe.
  always_ff @(posedge clk) begin
    if (rst)                 cfgLatQ <= '0;
    else if (strobe.cfgLoad) cfgLatQ <= cfgSrQ;
  end

  assert_hit_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.capture && hitQ) |=> hitQ);

  assert_hit_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobe.capture && !strobe.hitShift && !strobe.hitClear) |=> $stable(hitQ));

  assert_hit_shift_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.hitShift |=> (hitQ == $past(hitFromNext)));

  assert_hit_clear_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.hitClear |=> !hitQ);

  assert_cfg_shift_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.cfgShift |=> (cfgSrQ == {$past(cfgFromNext), $past(cfgSrQ[CFG_BITS-1:1])}));

  assert_cfg_load_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.cfgLoad |=> (cfgLatQ == $past(cfgSrQ)));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !strobe.cfgLoad |=> $stable(cfgLatQ));

  assert_copyback_R9: assert property (@(posedge clk) disable iff (rst)
    strobe.cfgCopyBack |=> (cfgSrQ == $past(cfgLatQ)));

  assert_path_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!strobe.cfgShift && !strobe.cfgCopyBack) |=> $stable(cfgSrQ));

endmodule

// File: rtl/pixchain_array.sv
module pixchain_array
  import pixchain_pkg::*;
#(
  parameter int NPIX = 2736
) (
  input  logic                      clk,
  input  logic                      rst,
  input  chainStrobe_t              strobe,
  input  logic                      serIn,
  input  logic [NPIX-1:0]           discIn,
  output logic                      serOut,
  output logic [NPIX*TRIM_BITS-1:0] cfgTrim,
  output logic [NPIX-1:0]           cfgPreampEn,
  output logic [NPIX-1:0]           cfgInjEn,
  output logic [NPIX-1:0]           cfgMonEn
);

  logic [NPIX-1:0]     hitQ;
  logic [CFG_BITS-1:0] srQ  [NPIX];
  pixCfg_t             latQ [NPIX];

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic hitNext;
    logic cfgNext;

    if (p == NPIX - 1) begin : g_tail
      assign hitNext = serIn;
      assign cfgNext = serIn;
    end else begin : g_link
      assign hitNext = hitQ[p+1];
      assign cfgNext = srQ[p+1][0];
    end

    pixchain_cell u_cell (
      .clk         (clk),
      .rst         (rst),
      .strobe      (strobe),
      .discIn      (discIn[p]),
      .hitFromNext (hitNext),
      .cfgFromNext (cfgNext),
      .hitQ        (hitQ[p]),
      .cfgSrQ      (srQ[p]),
      .cfgLatQ     (latQ[p])
    );

    assign cfgTrim[p*TRIM_BITS +: TRIM_BITS] = latQ[p].trim;
    assign cfgPreampEn[p]                    = latQ[p].preampEn;
    assign cfgInjEn[p]                       = latQ[p].injEn;
    assign cfgMonEn[p]                       = latQ[p].monEn;
  end

  assign serOut = strobe.outFromCfg ? srQ[0][0] : hitQ[0];

endmodule

// File: rtl/pixmatrix_chain.sv
module pixmatrix_chain
  import pixchain_pkg::*;
#(
  parameter int COLS = 24,
  parameter int ROWS = 114
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           serIn,
  input  logic                           shiftEn,
  input  logic                           loadStb,
  input  logic [1:0]                     modeSel,
  input  logic [COLS*ROWS-1:0]           discIn,
  output logic                           serOut,
  output logic [COLS*ROWS*TRIM_BITS-1:0] cfgTrim,
  output logic [COLS*ROWS-1:0]           cfgPreampEn,
  output logic [COLS*ROWS-1:0]           cfgInjEn,
  output logic [COLS*ROWS-1:0]           cfgMonEn
);

  localparam int NPIX = COLS * ROWS;

  chainStrobe_t strobe;

  pixchain_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .shiftEn (shiftEn),
    .loadStb (loadStb),
    .modeSel (modeSel),
    .strobe  (strobe)
  );

  pixchain_array #(.NPIX(NPIX)) u_array (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .serIn       (serIn),
    .discIn      (discIn),
    .serOut      (serOut),
    .cfgTrim     (cfgTrim),
    .cfgPreampEn (cfgPreampEn),
    .cfgInjEn    (cfgInjEn),
    .cfgMonEn    (cfgMonEn)
  );

endmodule

// File: tb/test_pixmatrix_chain.sv
module test_pixmatrix_chain;

  localparam int COLS = 3;
  localparam int ROWS = 4;
  localparam int NPIX = COLS * ROWS;
  localparam int NCFG = 7 * NPIX;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              serIn = 1'b0;
  logic              shiftEn = 1'b0;
  logic              loadStb = 1'b0;
  logic [1:0]        modeSel = 2'd0;
  logic [NPIX-1:0]   discIn = '0;
  logic              serOut;
  logic [NPIX*4-1:0] cfgTrim;
  logic [NPIX-1:0]   cfgPreampEn, cfgInjEn, cfgMonEn;

  pixmatrix_chain #(.COLS(COLS), .ROWS(ROWS)) i_pixmatrix_chain (
    .clk(clk), .rst(rst), .serIn(serIn), .shiftEn(shiftEn), .loadStb(loadStb),
    .modeSel(modeSel), .discIn(discIn), .serOut(serOut), .cfgTrim(cfgTrim),
    .cfgPreampEn(cfgPreampEn), .cfgInjEn(cfgInjEn), .cfgMonEn(cfgMonEn)
  );

  always #2.5 clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;

  logic [NPIX-1:0] hitExp = '0;
  logic [6:0]      cfgExp [NPIX];
  logic [6:0]      wordA  [NPIX];
  logic [6:0]      wordB  [NPIX];

  bit    expQ [$];
  string tagQ [$];

  // Monitor: compares serOut with the scoreboard at each falling edge.
  always @(negedge clk) begin
    bit    e;
    string t;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      testsRun++;
      if (serOut !== e) begin
        testsFailed++;
        $display("FAIL %s: serOut=%0b expected %0b", t, serOut, e);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      testsFailed++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic readHits(input string tag, input logic [NPIX-1:0] fill);
    modeSel = 2'd0;
    for (int i = 0; i < NPIX; i++) begin
      serIn   = fill[i];
      shiftEn = 1'b1;
      expQ.push_back(hitExp[i]);
      tagQ.push_back(tag);
      tick();
    end
    shiftEn = 1'b0;
    serIn   = 1'b0;
    hitExp  = fill;
  endtask

  task automatic writeCfg(input logic [6:0] w [NPIX]);
    modeSel = 2'd1;
    for (int j = 0; j < NCFG; j++) begin
      serIn   = w[j / 7][j % 7];
      shiftEn = 1'b1;
      tick();
    end
    shiftEn = 1'b0;
    serIn   = 1'b0;
  endtask

  task automatic pulseLoad();
    loadStb = 1'b1;
    tick();
    loadStb = 1'b0;
  endtask

  task automatic readCfg(input string tag);
    modeSel = 2'd2;
    pulseLoad();
    for (int j = 0; j < NCFG; j++) begin
      shiftEn = 1'b1;
      expQ.push_back(cfgExp[j / 7][j % 7]);
      tagQ.push_back(tag);
      tick();
    end
    shiftEn = 1'b0;
    modeSel = 2'd0;
  endtask

  task automatic checkCfg(input string tag);
    for (int p = 0; p < NPIX; p++) begin
      logic [6:0] got;
      got = {cfgMonEn[p], cfgInjEn[p], cfgPreampEn[p], cfgTrim[p*4 +: 4]};
      testsRun++;
      if (got !== cfgExp[p]) begin
        testsFailed++;
        $display("FAIL %s: pixel %0d cfg=%h expected %h", tag, p, got, cfgExp[p]);
      end
    end
  endtask

  task automatic pulseDisc(input logic [NPIX-1:0] mask);
    discIn = mask;
    tick();
    tick();
    discIn = '0;
    tick();
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    tick();
    hitExp = '0;
    for (int p = 0; p < NPIX; p++) cfgExp[p] = '0;
  endtask

  initial begin
    for (int p = 0; p < NPIX; p++) begin
      wordA[p] = 7'((p * 37 + 5) & 8'h7f);
      wordB[p] = 7'((p * 53 + 90) & 8'h7f);
    end

    // R1: reset state
    doReset();
    checkCfg("R1 cfg after reset");
    readHits("R1 hits after reset", '0);
    readCfg("R1 readback after reset");

    // R7: shifting alone leaves latches untouched, strobe loads them
    writeCfg(wordA);
    checkCfg("R7 before strobe");
    modeSel = 2'd1;
    pulseLoad();
    for (int p = 0; p < NPIX; p++) cfgExp[p] = wordA[p];
    checkCfg("R7 after strobe");

    // R2 / R4: capture pattern, sticky second pulse, ordered readout with fill
    modeSel = 2'd0;
    pulseDisc(12'h821);
    pulseDisc(12'h001);
    tick();
    hitExp = 12'h821;
    readHits("R2_R4 captured hits", 12'hA5C);
    readHits("R4 serial fill", '0);

    // R3: discriminator rises during shifting and stays high afterwards
    pulseDisc(12'h084);
    hitExp = 12'h084;
    discIn = 12'h018;
    readHits("R3 ignore during shift", '0);
    tick();
    discIn = '0;
    tick();
    readHits("R3 no late capture", '0);

    // R5: capture then clear
    pulseDisc(12'h202);
    modeSel = 2'd0;
    pulseLoad();
    hitExp = '0;
    readHits("R5 cleared hits", '0);

    // R8: latches survive all hit-mode activity
    checkCfg("R8 after hit traffic");

    // R9 / R6: readback of written words, then latches still intact
    readCfg("R9_R6 readback");
    checkCfg("R8 after readback");

    // R10: hold with shiftEn low, then strobe together with shiftEn
    writeCfg(wordB);
    checkCfg("R8 before second strobe");
    modeSel = 2'd1;
    for (int i = 0; i < 9; i++) begin
      serIn = i[0];
      tick();
    end
    serIn   = 1'b0;
    shiftEn = 1'b1;
    pulseLoad();
    shiftEn = 1'b0;
    for (int p = 0; p < NPIX; p++) cfgExp[p] = wordB[p];
    checkCfg("R10 strobe wins over shift");
    readCfg("R10 path held");

    // R11: idle mode does nothing
    pulseDisc(12'h410);
    hitExp = 12'h410;
    modeSel = 2'd3;
    shiftEn = 1'b1;
    serIn   = 1'b1;
    pulseDisc(12'h003);
    loadStb = 1'b1;
    tick();
    tick();
    loadStb = 1'b0;
    shiftEn = 1'b0;
    serIn   = 1'b0;
    checkCfg("R11 idle keeps latches");
    readHits("R11 idle keeps hits", '0);

    // R1: reset in mid-run clears hits and latches
    pulseDisc(12'h0f0);
    doReset();
    checkCfg("R1 cfg after second reset");
    readHits("R1 hits after second reset", '0);

    tick();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule